// File: doc/BRIEF.md
# Half-Duplex Collision, Heartbeat and Jabber Supervisor

This block drives the collision indication that a 10/100 transceiver presents to the MAC on its media-independent interface. It watches the MAC's transmit enable and the receive-side carrier activity. When both are active at once in half duplex, at either speed, it reports a collision. In full duplex the collision output stays low. At 10 Mb/s half duplex, with the heartbeat feature turned on, it also sends a short signal-quality-error pulse on the same output a fixed time after every transmission ends. This tells the MAC that the collision path works.

The block also contains a jabber guard. If the MAC holds transmit enable for too long, the guard cuts the transmit enable that goes on to the line encoder and raises a jabber flag. It releases only after the MAC has stayed quiet for a much longer time. A sticky status bit records that jabber happened at least once since reset. All times are counted in strobes from a timebase input. Their lengths are parameters given in nanoseconds or microseconds relative to the strobe period, so a simulation can use short windows.

Top module: `halfdup_col_supervisor`

## Requirements
- R1: In half duplex (`full_duplex`=0), at either speed, `col` is 1 in the cycle after a clock edge at which the gated transmit enable `tx_en_out` and `rx_active` were both 1.
- R2: In full duplex (`full_duplex`=1), `col` is 0 in the cycle after every clock edge at which `full_duplex` was 1, whatever the other inputs are.
- R3: At 10 Mb/s half duplex (`speed_100`=0, `full_duplex`=0) with `hb_en`=1, the end of a transmission arms a heartbeat. The end is the first edge that sees `tx_en_out` low after it was high. `col` then rises on the edge that counts the HB_DELAY-th strobe after that edge, and stays high for exactly HB_PULSE strobes.
- R4: No heartbeat pulse is produced when `hb_en`=0, when `full_duplex`=1, or when `speed_100`=1. If any of these holds at an edge, a pending or running pulse is dropped at that edge.
- R5: If `tx_en_out` rises again while a heartbeat is waiting out its delay, that heartbeat is cancelled and no pulse follows for it.
- R6: The heartbeat and jabber timers advance only on clock edges where `tick`=1. While `tick` is held at 0, no pulse starts and no jabber state changes.
- R7: When `tx_en_in` has been high for JAB_ON consecutive strobes, `jabber` rises. From then on `tx_en_out` is 0 even though `tx_en_in` is 1.
- R8: While `jabber` is 1, no collision is reported for receive activity, and the cut-off of transmission caused by jabber does not arm a heartbeat.
- R9: `jabber` falls only after `tx_en_in` has stayed low for JAB_OFF consecutive strobes. Any strobe-period with `tx_en_in` high restarts that count.
- R10: `jabber_seen` becomes 1 when jabber activates and stays 1, even after jabber releases, until reset.
- R11: After a synchronous active-low reset, `col`, `jabber` and `jabber_seen` are 0, and `tx_en_out` equals `tx_en_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase strobe, one clock wide, period TICK_NS |
| tx_en_in | input | 1 | Transmit enable from the MAC |
| rx_active | input | 1 | Receive carrier activity from the receive path |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| hb_en | input | 1 | 1 = heartbeat pulse enabled |
| tx_en_out | output | 1 | Transmit enable passed on to the line encoder, forced low during jabber |
| col | output | 1 | Collision indication, including the heartbeat pulse |
| jabber | output | 1 | Jabber lockout active |
| jabber_seen | output | 1 | Sticky record that jabber has occurred since reset |

## Verification
The hardest conditions to reach are where the timers interact. One is a jabber cut-off that drops the gated transmit enable while the heartbeat could arm. Another is a release count that is restarted partway by a short burst of transmit enable. The stimulus reaches them by holding transmit enable for the whole activation window in 10 Mb/s half duplex with the heartbeat enabled, then watching a full heartbeat window pass with no pulse. It then drops transmit enable, raises it for a single cycle close to the end of the release window, and measures the release from the second drop. A third case freezes the strobe inside the heartbeat delay, so that the delay is shown to count strobes and not clock cycles.

// File: rtl/halfdup_col_pkg.sv
// Package: shared types and helpers for the half-duplex collision supervisor.
// Assumes: nothing beyond standard SystemVerilog.
package halfdup_col_pkg;

    // Heartbeat sequencer states.
    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_PULSE = 2'd2
    } hb_state_e;

    // Width needed to hold values 0..limit-1 (at least one bit).
    function automatic int cnt_bits(input int limit);
        int w;
        w = $clog2(limit);
        if (w < 1) w = 1;
        return w;
    endfunction

endpackage

// File: rtl/halfdup_col_detect.sv
// Module: registered collision detector.
// Reports the overlap of line transmit and receive activity in half duplex.
// Assumes: tx_line is already gated by the jabber guard.
module halfdup_col_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_line,
    input  logic rx_active,
    input  logic full_duplex,
    output logic overlap
);

    // Register the half-duplex overlap of transmit and receive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overlap <= 1'b0;
        end else begin
            overlap <= tx_line & rx_active & ~full_duplex;
        end
    end

endmodule

// File: rtl/halfdup_sqe_timer.sv
// Module: heartbeat (signal quality error test) sequencer.
// After the end of a transmission it waits DLY_TICKS strobes, then drives
// a pulse for PULSE_TICKS strobes. A new transmission during the wait, or
// the loss of the permitting mode, cancels it.
// Assumes: tick is a one-cycle strobe; hb_allowed already combines the
// mode conditions; a fall of tx_line while jab_active is a cut-off.
module halfdup_sqe_timer
    import halfdup_col_pkg::*;
#(
    parameter int DLY_TICKS   = 12,
    parameter int PULSE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_line,
    input  logic jab_active,
    input  logic hb_allowed,
    output logic pulse
);

    localparam int MAXT = (DLY_TICKS > PULSE_TICKS) ? DLY_TICKS : PULSE_TICKS;
    localparam int CW   = cnt_bits(MAXT);
    localparam logic [CW-1:0] DLY_LAST   = CW'(DLY_TICKS - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);

    hb_state_e      state;
    logic [CW-1:0]  cnt;
    logic           tx_prev;
    logic           tx_fall;

    // End of transmission seen on the gated line enable.
    assign tx_fall = tx_prev & ~tx_line;

    // Remember last cycle's line enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_prev <= 1'b0;
        else        tx_prev <= tx_line;
    end

    // Sequence through wait and pulse phases on timebase strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HB_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                HB_IDLE: begin
                    cnt <= '0;
                    if (tx_fall && hb_allowed && !jab_active) begin
                        state <= HB_WAIT;
                    end
                end
                HB_WAIT: begin
                    if (!hb_allowed || tx_line) begin
                        state <= HB_IDLE;
                        cnt   <= '0;
                    end else if (tick) begin
                        if (cnt == DLY_LAST) begin
                            state <= HB_PULSE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                HB_PULSE: begin
                    if (!hb_allowed) begin
                        state <= HB_IDLE;
                        cnt   <= '0;
                    end else if (tick) begin
                        if (cnt == PULSE_LAST) begin
                            state <= HB_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= HB_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Pulse is high for the whole pulse phase.
    assign pulse = (state == HB_PULSE);

endmodule

// File: rtl/halfdup_jabber_guard.sv
// Module: jabber watchdog.
// Activates after ON_TICKS consecutive strobes of transmit request; releases
// after OFF_TICKS consecutive strobes with the request low. One counter
// serves both phases. A sticky flag records any activation.
// Assumes: tick is a one-cycle strobe; reset clears the sticky flag.
module halfdup_jabber_guard
    import halfdup_col_pkg::*;
#(
    parameter int ON_TICKS  = 850000,
    parameter int OFF_TICKS = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_req,
    output logic jab_active,
    output logic jab_seen
);

    localparam int MAXT = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
    localparam int CW   = cnt_bits(MAXT);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);

    logic [CW-1:0] run_cnt;

    // Count continuous transmit (armed) or continuous quiet (locked).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jab_active <= 1'b0;
            jab_seen   <= 1'b0;
            run_cnt    <= '0;
        end else if (!jab_active) begin
            if (!tx_req) begin
                run_cnt <= '0;
            end else if (tick) begin
                if (run_cnt == ON_LAST) begin
                    jab_active <= 1'b1;
                    jab_seen   <= 1'b1;
                    run_cnt    <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end else begin
            if (tx_req) begin
                run_cnt <= '0;
            end else if (tick) begin
                if (run_cnt == OFF_LAST) begin
                    jab_active <= 1'b0;
                    run_cnt    <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/halfdup_col_supervisor.sv
// Module: top of the half-duplex collision, heartbeat and jabber supervisor.
// Gates the MAC transmit enable with the jabber lockout, detects collisions
// on the gated enable, and merges the heartbeat pulse onto the collision
// output. All durations are converted to strobe counts from TICK_NS.
// Assumes: tick has period TICK_NS; inputs are synchronous to clk.
module halfdup_col_supervisor #(
    parameter int TICK_NS     = 100,
    parameter int HB_DELAY_NS = 1200,
    parameter int HB_PULSE_NS = 1000,
    parameter int JAB_ON_US   = 85000,
    parameter int JAB_OFF_US  = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_en_in,
    input  logic rx_active,
    input  logic full_duplex,
    input  logic speed_100,
    input  logic hb_en,
    output logic tx_en_out,
    output logic col,
    output logic jabber,
    output logic jabber_seen
);

    localparam int HB_DLY_T   = (HB_DELAY_NS / TICK_NS > 0) ? HB_DELAY_NS / TICK_NS : 1;
    localparam int HB_PULSE_T = (HB_PULSE_NS / TICK_NS > 0) ? HB_PULSE_NS / TICK_NS : 1;
    localparam int JAB_ON_T   = ((JAB_ON_US * 1000) / TICK_NS > 0) ? (JAB_ON_US * 1000) / TICK_NS : 1;
    localparam int JAB_OFF_T  = ((JAB_OFF_US * 1000) / TICK_NS > 0) ? (JAB_OFF_US * 1000) / TICK_NS : 1;

    logic jab_active;
    logic overlap;
    logic hb_pulse;
    logic hb_allowed;

    // Heartbeat permitted only at 10 Mb/s half duplex with the feature on.
    assign hb_allowed = hb_en & ~full_duplex & ~speed_100;

    // Transmit passes to the line only outside jabber lockout.
    assign tx_en_out = tx_en_in & ~jab_active;

    halfdup_jabber_guard #(
        .ON_TICKS  (JAB_ON_T),
        .OFF_TICKS (JAB_OFF_T)
    ) u_jab (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tx_req     (tx_en_in),
        .jab_active (jab_active),
        .jab_seen   (jabber_seen)
    );

    halfdup_col_detect u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_line     (tx_en_out),
        .rx_active   (rx_active),
        .full_duplex (full_duplex),
        .overlap     (overlap)
    );

    halfdup_sqe_timer #(
        .DLY_TICKS   (HB_DLY_T),
        .PULSE_TICKS (HB_PULSE_T)
    ) u_sqe (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tx_line    (tx_en_out),
        .jab_active (jab_active),
        .hb_allowed (hb_allowed),
        .pulse      (hb_pulse)
    );

    // Collision output carries real collisions and the heartbeat.
    assign col    = overlap | hb_pulse;
    assign jabber = jab_active;

endmodule

// File: rtl/halfdup_col_checker.sv
// Module: assertion checker for the supervisor, bound to its ports.
// Assumes: synchronous active-low reset on rst_n.
module halfdup_col_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en_in,
    input logic rx_active,
    input logic full_duplex,
    input logic speed_100,
    input logic hb_en,
    input logic tx_en_out,
    input logic col,
    input logic jabber,
    input logic jabber_seen
);

    assert_col_on_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && tx_en_out && rx_active) |=> col);

    assert_fd_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |=> !col);

    assert_no_hb_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && !(tx_en_out && rx_active)) |=> !col);

    assert_no_hb_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hb_en && !(tx_en_out && rx_active)) |=> !col);

    assert_jab_needs_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jabber) |-> $past(tx_en_in));

    assert_release_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jabber) |-> !$past(tx_en_in));

    assert_jab_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |-> jabber_seen);

    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(jabber_seen));

endmodule

bind halfdup_col_supervisor halfdup_col_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en_in    (tx_en_in),
    .rx_active   (rx_active),
    .full_duplex (full_duplex),
    .speed_100   (speed_100),
    .hb_en       (hb_en),
    .tx_en_out   (tx_en_out),
    .col         (col),
    .jabber      (jabber),
    .jabber_seen (jabber_seen)
);

// File: tb/tb_halfdup_col_supervisor.sv
`timescale 1ns/1ps
module tb_halfdup_col_supervisor;

    localparam int DLY = 4;   // heartbeat delay in strobes
    localparam int WID = 3;   // heartbeat width in strobes
    localparam int JON = 20;  // jabber activation strobes
    localparam int JOF = 30;  // jabber release strobes

    logic clk = 1'b0;
    logic rst_n, tick, tx_en_in, rx_active, full_duplex, speed_100, hb_en;
    logic tx_en_out, col, jabber, jabber_seen;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    halfdup_col_supervisor #(
        .TICK_NS     (100),
        .HB_DELAY_NS (DLY * 100),
        .HB_PULSE_NS (WID * 100),
        .JAB_ON_US   (2),
        .JAB_OFF_US  (3)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .tx_en_in    (tx_en_in),
        .rx_active   (rx_active),
        .full_duplex (full_duplex),
        .speed_100   (speed_100),
        .hb_en       (hb_en),
        .tx_en_out   (tx_en_out),
        .col         (col),
        .jabber      (jabber),
        .jabber_seen (jabber_seen)
    );

    // Vector bits: {tx, rx, full_duplex, speed_100, expected col}
    localparam logic [4:0] VEC [8] = '{
        5'b11001, 5'b11011, 5'b11100, 5'b11110,
        5'b10000, 5'b01010, 5'b00000, 5'b11011
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Heartbeat mode: 10 Mb/s half duplex, heartbeat on, link quiet.
    task automatic hb_mode();
        tx_en_in = 0; rx_active = 0; full_duplex = 0; speed_100 = 0; hb_en = 1;
        adv(DLY + WID + 4);
    endtask

    // Transmit for a few cycles, then drop (caller checks after the drop).
    task automatic burst();
        tx_en_in = 1; adv(3); tx_en_in = 0;
    endtask

    // Count col highs over a full heartbeat window.
    task automatic quiet_window(input string tag);
        int highs = 0;
        for (int i = 0; i < DLY + WID + 3; i++) begin
            adv(1);
            if (col) highs++;
        end
        chk(tag, highs != 0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; tick = 1; tx_en_in = 0; rx_active = 0;
        full_duplex = 0; speed_100 = 0; hb_en = 0;
        adv(3);
        // R11: reset state
        chk("R11 col", col, 1'b0);
        chk("R11 jabber", jabber, 1'b0);
        chk("R11 jabber_seen", jabber_seen, 1'b0);
        tx_en_in = 1; #1;
        chk("R11 tx passthrough", tx_en_out, 1'b1);
        tx_en_in = 0;
        adv(1);
        rst_n = 1;
        adv(2);

        // R1 / R2: collision truth table, heartbeat off
        for (int i = 0; i < 8; i++) begin
            {tx_en_in, rx_active, full_duplex, speed_100} = VEC[i][4:1];
            adv(1);
            chk(VEC[i][2] ? "R2 full duplex col" : "R1 half duplex col", col, VEC[i][0]);
        end
        tx_en_in = 0; rx_active = 0;
        adv(2);

        // R3: heartbeat timing
        hb_mode(); burst();
        adv(DLY);       chk("R3 before pulse", col, 1'b0);
        adv(1);         chk("R3 pulse start", col, 1'b1);
        adv(WID - 1);   chk("R3 pulse end", col, 1'b1);
        adv(1);         chk("R3 after pulse", col, 1'b0);

        // R4: no heartbeat in full duplex, at 100 Mb/s, or disabled
        hb_mode(); full_duplex = 1; adv(1); burst(); quiet_window("R4 full duplex");
        hb_mode(); speed_100 = 1;   adv(1); burst(); quiet_window("R4 100 Mb/s");
        hb_mode(); hb_en = 0;       adv(1); burst(); quiet_window("R4 hb disabled");
        // R4: mode change mid-pulse drops it
        hb_mode(); burst();
        adv(DLY + 1);   chk("R4 pulse running", col, 1'b1);
        full_duplex = 1;
        adv(1);         chk("R4 pulse dropped", col, 1'b0);

        // R5: new transmit in delay window cancels
        hb_mode(); burst();
        adv(2); tx_en_in = 1;
        quiet_window("R5 cancel");
        tx_en_in = 0;
        adv(DLY + 1);   chk("R5 rearmed after cancel", col, 1'b1);

        // R6: frozen strobe holds the delay
        hb_mode(); burst();
        adv(1); tick = 0;
        adv(DLY + 6);   chk("R6 frozen no pulse", col, 1'b0);
        tick = 1;
        adv(DLY - 1);   chk("R6 before pulse", col, 1'b0);
        adv(1);         chk("R6 pulse after resume", col, 1'b1);

        // R7 / R8: jabber activation in heartbeat mode
        hb_mode();
        tx_en_in = 1;
        adv(JON - 1);   chk("R7 not yet jabber", jabber, 1'b0);
                        chk("R7 tx passes", tx_en_out, 1'b1);
        adv(1);         chk("R7 jabber on", jabber, 1'b1);
                        chk("R7 tx forced low", tx_en_out, 1'b0);
                        chk("R10 sticky set", jabber_seen, 1'b1);
        quiet_window("R8 no heartbeat on cutoff");
        rx_active = 1;
        adv(2);         chk("R8 no collision in jabber", col, 1'b0);
        rx_active = 0;

        // R9: release with restart
        tx_en_in = 0;
        adv(JOF - 3);   chk("R9 still locked", jabber, 1'b1);
        tx_en_in = 1; adv(1); tx_en_in = 0;
        adv(JOF - 1);   chk("R9 restarted count", jabber, 1'b1);
        adv(1);         chk("R9 released", jabber, 1'b0);
                        chk("R10 sticky held", jabber_seen, 1'b1);
        tx_en_in = 1; #1;
        chk("R9 tx passes after release", tx_en_out, 1'b1);
        tx_en_in = 0;
        adv(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule